// File: doc/BRIEF.md
# Four-Bit Stack Calculator Core

This core is a nibble-wide accumulator machine. It holds one working register and a small last-in-first-out store of nibbles. A 7-bit command word selects the operation. A single-cycle execute strobe commits exactly one command per strobe cycle. Between strobes the core holds its state, whatever the command inputs show.

The top three command bits form the primary opcode. When they are not all ones, the low four bits are an immediate operand for arithmetic, logic, clear or load. When they are all ones, bits 3:1 choose an extended operation and bit 0 is ignored. The extended operations are arithmetic or logic against the stack top, a push of the register, a pop into the register, or no operation.

Three outputs carry state. The register drives a hex display. The stack top drives a binary display and reads zero when the stack is empty. An occupancy count is also provided.

Top module: `nibcalc_core`

## Requirements
- R1: A synchronous active-high reset sets the register to 0, empties the stack (count 0) and makes the stack-top output read 0.
- R2: While the execute strobe is low, no command changes the register, the stack top or the occupancy count.
- R3: Primary opcode 000 adds the immediate to the register, modulo 16. Primary opcode 100 stores the register minus the immediate, modulo 16.
- R4: Primary opcodes 001, 010 and 011 store the bitwise AND, OR and XOR of the register and the immediate.
- R5: Primary opcode 101 sets the register to 0 whatever bits 3:0 hold. Primary opcode 110 copies bits 3:0 into the register.
- R6: With primary opcode 111, bits 3:1 = 000, 001, 010, 011 and 100 apply ADD, AND, OR, XOR and SUB (register minus top) with the stack top as operand. These operations do not pop, and bit 0 has no effect.
- R7: Primary 111 with bits 3:1 = 101 pushes the register. The stack top then equals the register, the count rises by one and the register is unchanged.
- R8: Primary 111 with bits 3:1 = 110 pops. The register takes the old top, the count falls by one and the next entry becomes the top.
- R9: A push on a full stack (count 4) discards the bottom entry and keeps the count at 4.
- R10: A pop on an empty stack loads 0 into the register and leaves the count at 0.
- R11: Primary 111 with bits 3:1 = 111 changes nothing.
- R12: Each cycle with the strobe high executes the present command exactly once, so a strobe held for two cycles executes it twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe, one command per high cycle |
| cmd_i | input | 7 | Command word: primary opcode in 6:4, operand or extended code in 3:0 |
| acc_o | output | 4 | Working register |
| top_o | output | 4 | Stack top, 0 when empty |
| depth_o | output | 3 | Number of stack entries held (0 to 4) |

## Verification
Two functions can land on the same clock edge. The first is the pop, which writes the register from the stack top while the stack shifts up. The second is the push on a full stack, which loads the new top while the bottom entry falls off. The bench provokes the first by popping a two-deep stack and then an empty one. It provokes the second by pushing five distinct values and popping them all back. It judges both by the register value, top and count seen after each edge, and by the exact order in which the values return.

// File: rtl/nibcalc_pkg.sv
package nibcalc_pkg;

    localparam int NIB_W = 4;

    // primary opcode field (command bits 6:4)
    localparam logic [2:0] PRI_ADD  = 3'b000;
    localparam logic [2:0] PRI_AND  = 3'b001;
    localparam logic [2:0] PRI_OR   = 3'b010;
    localparam logic [2:0] PRI_XOR  = 3'b011;
    localparam logic [2:0] PRI_SUB  = 3'b100;
    localparam logic [2:0] PRI_CLR  = 3'b101;
    localparam logic [2:0] PRI_LOAD = 3'b110;
    localparam logic [2:0] PRI_EXT  = 3'b111;

    // extended code field (command bits 3:1 when primary is PRI_EXT)
    localparam logic [2:0] EXT_ADD  = 3'b000;
    localparam logic [2:0] EXT_AND  = 3'b001;
    localparam logic [2:0] EXT_OR   = 3'b010;
    localparam logic [2:0] EXT_XOR  = 3'b011;
    localparam logic [2:0] EXT_SUB  = 3'b100;
    localparam logic [2:0] EXT_PUSH = 3'b101;
    localparam logic [2:0] EXT_POP  = 3'b110;
    localparam logic [2:0] EXT_NOP  = 3'b111;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_SUB,
        OP_CLR,
        OP_LOAD,
        OP_PUSH,
        OP_POP,
        OP_NOP
    } op_e;

    typedef struct packed {
        op_e  op;
        logic stk_src;   // operand comes from stack top
    } dec_t;

endpackage

// File: rtl/nibcalc_decode.sv
module nibcalc_decode
    import nibcalc_pkg::*;
#(
    parameter int DATA_W = NIB_W,
    localparam int CMD_W = DATA_W + 3
) (
    input  logic [CMD_W-1:0] cmd,
    output dec_t             dec
);

    logic [2:0] pri;
    logic [2:0] ext;

    assign pri = cmd[CMD_W-1 -: 3];
    assign ext = cmd[DATA_W-1 -: 3];

    always_comb begin
        dec = '{op: OP_NOP, stk_src: 1'b0};
        if (pri != PRI_EXT) begin
            case (pri)
                PRI_ADD:  dec.op = OP_ADD;
                PRI_AND:  dec.op = OP_AND;
                PRI_OR:   dec.op = OP_OR;
                PRI_XOR:  dec.op = OP_XOR;
                PRI_SUB:  dec.op = OP_SUB;
                PRI_CLR:  dec.op = OP_CLR;
                PRI_LOAD: dec.op = OP_LOAD;
                default:  dec.op = OP_NOP;
            endcase
        end else begin
            dec.stk_src = 1'b1;
            case (ext)
                EXT_ADD:  dec.op = OP_ADD;
                EXT_AND:  dec.op = OP_AND;
                EXT_OR:   dec.op = OP_OR;
                EXT_XOR:  dec.op = OP_XOR;
                EXT_SUB:  dec.op = OP_SUB;
                EXT_PUSH: dec.op = OP_PUSH;
                EXT_POP:  dec.op = OP_POP;
                default:  dec.op = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/nibcalc_alu.sv
module nibcalc_alu
    import nibcalc_pkg::*;
#(
    parameter int DATA_W = NIB_W
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        case (op)
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            OP_XOR:  res = lhs ^ rhs;
            default: res = lhs;
        endcase
    end

endmodule

// File: rtl/nibcalc_stack.sv
module nibcalc_stack #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] top,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] ent;   // index 0 is the top
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                stk_d.ent[i] = stk_q.ent[i-1];
            end
            stk_d.ent[0] = din;
            if (stk_q.cnt != FULL_CNT) begin
                stk_d.cnt = stk_q.cnt + 1'b1;
            end
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                stk_d.ent[i] = stk_q.ent[i+1];
            end
            stk_d.ent[DEPTH-1] = '0;
            if (stk_q.cnt != '0) begin
                stk_d.cnt = stk_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign top   = (stk_q.cnt == '0) ? '0 : stk_q.ent[0];
    assign count = stk_q.cnt;

    AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push, pop}));                                        // R12
    AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);                                            // R9
    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (rst)
        push |=> top == $past(din));                                   // R7
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (push && count == FULL_CNT) |=> count == FULL_CNT);            // R9
    AST_EMPTY_POP_STAYS: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0) |=> count == '0);                         // R10
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop && count != '0) |=> count == $past(count) - 1'b1);        // R8

endmodule

// File: rtl/nibcalc_core.sv
module nibcalc_core
    import nibcalc_pkg::*;
#(
    parameter int DATA_W = NIB_W,
    parameter int DEPTH  = 4,
    localparam int CMD_W = DATA_W + 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_i,
    input  logic [CMD_W-1:0]  cmd_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] top_o,
    output logic [CNT_W-1:0]  depth_o
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
    } core_t;

    core_t             core_d, core_q;
    dec_t              dec;
    logic [DATA_W-1:0] imm;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] stk_top;
    logic [CNT_W-1:0]  stk_cnt;
    logic              do_push;
    logic              do_pop;

    assign imm = cmd_i[DATA_W-1:0];

    nibcalc_decode #(.DATA_W(DATA_W)) u_dec (
        .cmd (cmd_i),
        .dec (dec)
    );

    assign operand = dec.stk_src ? stk_top : imm;

    nibcalc_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (dec.op),
        .lhs (core_q.acc),
        .rhs (operand),
        .res (alu_res)
    );

    assign do_push = exec_i && (dec.op == OP_PUSH);
    assign do_pop  = exec_i && (dec.op == OP_POP);

    nibcalc_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (do_push),
        .pop   (do_pop),
        .din   (core_q.acc),
        .top   (stk_top),
        .count (stk_cnt)
    );

    always_comb begin
        core_d = core_q;
        if (exec_i) begin
            case (dec.op)
                OP_ADD, OP_AND, OP_OR, OP_XOR, OP_SUB: core_d.acc = alu_res;
                OP_CLR:  core_d.acc = '0;
                OP_LOAD: core_d.acc = imm;
                OP_POP:  core_d.acc = stk_top;
                default: core_d.acc = core_q.acc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign acc_o   = core_q.acc;
    assign top_o   = stk_top;
    assign depth_o = stk_cnt;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> ($stable(acc_o) && $stable(depth_o) && $stable(top_o))); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (exec_i && cmd_i[CMD_W-1 -: 3] == PRI_CLR) |=> acc_o == '0);       // R5
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (exec_i && cmd_i[CMD_W-1 -: 3] == PRI_LOAD)
            |=> acc_o == $past(cmd_i[DATA_W-1:0]));                         // R5
    AST_POP_TAKES_TOP: assert property (@(posedge clk) disable iff (rst)
        (exec_i && cmd_i[CMD_W-1 -: 3] == PRI_EXT
                && cmd_i[DATA_W-1 -: 3] == EXT_POP)
            |=> acc_o == $past(top_o));                                     // R8
    AST_PUSH_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (exec_i && cmd_i[CMD_W-1 -: 3] == PRI_EXT
                && cmd_i[DATA_W-1 -: 3] == EXT_PUSH)
            |=> $stable(acc_o));                                            // R7
    AST_EMPTY_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        depth_o == '0 |-> top_o == '0);                                     // R1

endmodule

// File: tb/sim_nibcalc_core.sv
module sim_nibcalc_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_i = 1'b0;
    logic [6:0] cmd_i = 7'h7E;
    logic [3:0] acc_o, top_o;
    logic [2:0] depth_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    nibcalc_core u0 (
        .clk(clk), .rst(rst), .exec_i(exec_i), .cmd_i(cmd_i),
        .acc_o(acc_o), .top_o(top_o), .depth_o(depth_o)
    );

    // {cmd, acc, top, depth, req}
    localparam int NV = 22;
    localparam logic [21:0] VEC [NV] = '{
        {7'h65, 4'h5, 4'h0, 3'd0, 4'd5},
        {7'h0C, 4'h1, 4'h0, 3'd0, 4'd3},
        {7'h43, 4'hE, 4'h0, 3'd0, 4'd3},
        {7'h16, 4'h6, 4'h0, 3'd0, 4'd4},
        {7'h29, 4'hF, 4'h0, 3'd0, 4'd4},
        {7'h35, 4'hA, 4'h0, 3'd0, 4'd4},
        {7'h7A, 4'hA, 4'hA, 3'd1, 4'd7},
        {7'h5F, 4'h0, 4'hA, 3'd1, 4'd5},
        {7'h63, 4'h3, 4'hA, 3'd1, 4'd5},
        {7'h7B, 4'h3, 4'h3, 3'd2, 4'd7},
        {7'h70, 4'h6, 4'h3, 3'd2, 4'd6},
        {7'h79, 4'h3, 4'h3, 3'd2, 4'd6},
        {7'h76, 4'h0, 4'h3, 3'd2, 4'd6},
        {7'h69, 4'h9, 4'h3, 3'd2, 4'd5},
        {7'h74, 4'hB, 4'h3, 3'd2, 4'd6},
        {7'h72, 4'h3, 4'h3, 3'd2, 4'd6},
        {7'h7E, 4'h3, 4'h3, 3'd2, 4'd11},
        {7'h7C, 4'h3, 4'hA, 3'd1, 4'd8},
        {7'h7D, 4'hA, 4'h0, 3'd0, 4'd8},
        {7'h7C, 4'h0, 4'h0, 3'd0, 4'd10},
        {7'h6F, 4'hF, 4'h0, 3'd0, 4'd5},
        {7'h78, 4'hF, 4'h0, 3'd0, 4'd6}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd10:   return "R10";
            4'd11:   return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] ea,
                         input logic [3:0] et, input logic [2:0] ed);
        n_chk++;
        if (acc_o !== ea || top_o !== et || depth_o !== ed) begin
            n_fail++;
            $display("FAIL %s: acc=%h top=%h depth=%0d expected acc=%h top=%h depth=%0d",
                     tag, acc_o, top_o, depth_o, ea, et, ed);
        end
    endtask

    // one command with a one-cycle strobe; outputs sampled at the next falling edge
    task automatic run(input logic [6:0] c);
        @(negedge clk);
        cmd_i  = c;
        exec_i = 1'b1;
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 4'h0, 4'h0, 3'd0);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][21:15]);
            check(req_name(VEC[i][3:0]), VEC[i][14:11], VEC[i][10:7], VEC[i][6:4]);
        end

        // R2: commands shown without a strobe do nothing (acc F, empty)
        cmd_i = 7'h60;
        repeat (3) @(negedge clk);
        check("R2 load held off", 4'hF, 4'h0, 3'd0);
        cmd_i = 7'h7A;
        repeat (2) @(negedge clk);
        check("R2 push held off", 4'hF, 4'h0, 3'd0);

        // R12: strobe held two cycles adds twice
        run(7'h61);
        @(negedge clk);
        cmd_i  = 7'h01;
        exec_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        exec_i = 1'b0;
        check("R12 two strobe cycles", 4'h3, 4'h0, 3'd0);

        // R9: fill with 1..4, then push 5 onto a full stack
        for (int v = 1; v <= 5; v++) begin
            run({3'b110, 4'(v)});
            run(7'h7A);
        end
        check("R9 push on full", 4'h5, 4'h5, 3'd4);
        run(7'h7C);
        check("R9 pop after overflow 5", 4'h5, 4'h4, 3'd3);
        run(7'h7C);
        check("R9 pop 4", 4'h4, 4'h3, 3'd2);
        run(7'h7C);
        check("R9 pop 3", 4'h3, 4'h2, 3'd1);
        run(7'h7C);
        check("R9 bottom 1 discarded", 4'h2, 4'h0, 3'd0);
        run(7'h7C);
        check("R10 pop empty", 4'h0, 4'h0, 3'd0);

        // R1: reset mid-run
        run(7'h67);
        run(7'h7A);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset after push", 4'h0, 4'h0, 3'd0);

        finish_up();
    end

endmodule